// File: doc/BRIEF.md
# Two-Thread Core Idle-State Resolver

This block tracks the idle state of each hardware thread in a core and derives one core power state from them. A thread that is running (C0) may ask for an idle state: C1, C1E, C3 or C6. It may also give a substate hint and say whether it went idle through the monitor-wait path. The core state is the shallowest of the thread states, so the core is only as deep as its most active thread.

Wakeup events bring threads back to C0. An interrupt wakes its own thread. A write hit on the monitored address wakes only those threads that went idle through monitor-wait. When the whole core sits in C6, an interrupt to any thread wakes every thread. Each thread that leaves idle produces a one-cycle wake pulse. Clock and power gating, cache flushing and package-level state are handled elsewhere.

Each thread runs a small state machine. Its states are `ST_C0`, `ST_C1`, `ST_C1E`, `ST_C3` and `ST_C6`. The transitions are:
- **enter**: `ST_C0` moves to the requested idle state when a valid request arrives with no interrupt.
- **wake**: any idle state moves back to `ST_C0` on a wake event.
- **hold**: in all other cases the thread keeps its state.

Top module: `cstate_resolver`

## Requirements
- R1: After reset every thread is in C0, every substate is 0, the core state is C0 and no wake pulse is high.
- R2: States are encoded C0=0, C1=1, C1E=2, C3=3, C6=4, three bits per thread, with thread i at bits [3i+2:3i] of `thr_state`. A valid request from a thread in C0 for codes 1 to 4 sets that thread's state on the next clock edge. The substate hint is latched at the same edge.
- R3: `core_state` always equals the numerically lowest of the thread states.
- R4: An interrupt to an idle thread returns it to C0 on the next edge.
- R5: A monitored-address hit returns an idle thread to C0 only if that thread entered idle with the monitor-wait flag set. Other idle threads are unaffected.
- R6: When the core state is C1, C1E or C3, an interrupt to one thread wakes only that thread. The core state then reads C0.
- R7: When the core state is C6, an interrupt to any thread wakes all threads on the next edge.
- R8: A C6 request records substate 0, whatever hint it carries. Other idle states keep their hint.
- R9: If a request and an interrupt reach the same thread in the same cycle, the thread stays in C0.
- R10: A thread's wake bit is high for exactly the one cycle in which that thread has just returned from idle to C0, and at no other time.
- R11: Requests from a thread that is already idle are ignored.
- R12: Request codes 0 and 5 to 7 are ignored, and the thread stays in C0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | NUM_THR | Per-thread idle request strobe |
| req_state | input | 3*NUM_THR | Per-thread requested state code |
| req_sub | input | SUB_W*NUM_THR | Per-thread substate hint |
| req_mwait | input | NUM_THR | Request entered through the monitor-wait path |
| irq | input | NUM_THR | Per-thread interrupt |
| mon_hit | input | 1 | Write hit on the monitored address |
| thr_state | output | 3*NUM_THR | Current state of each thread |
| thr_sub | output | SUB_W*NUM_THR | Latched substate of each thread |
| core_state | output | 3 | Resolved core state |
| wake | output | NUM_THR | One-cycle pulse per thread leaving idle |

## Verification
Assertions check five rules on every cycle:
- a wake pulse appears only on the step from idle to C0 (R10);
- an idle thread with no wake event holds its state (R11);
- a thread in C6 carries substate 0 (R8);
- an interrupt in C0 keeps the thread in C0 (R9);
- a C6-wide interrupt empties the core (R7).

Other behaviour depends on particular combinations of thread states and can only be shown by the bench's scenarios. This covers the shallowest-state resolution with mixed depths and the single-thread wake scope in shallower core states. It also covers the monitor hit sparing threads that went idle without monitor-wait, and the rejection of bad codes.

// File: rtl/cstate_pkg.sv
package cstate_pkg;
    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_C0  = 3'd0,
        ST_C1  = 3'd1,
        ST_C1E = 3'd2,
        ST_C3  = 3'd3,
        ST_C6  = 3'd4
    } cstate_e;

    localparam logic [ST_W-1:0] ST_MIN_IDLE = 3'd1;
    localparam logic [ST_W-1:0] ST_MAX_IDLE = 3'd4;
endpackage

// File: rtl/cstate_thread_fsm.sv
module cstate_thread_fsm
    import cstate_pkg::*;
#(
    parameter int SUB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ST_W-1:0]      req_state,
    input  logic [SUB_W-1:0]     req_sub,
    input  logic                 req_mwait,
    input  logic                 irq,
    input  logic                 mon_hit,
    input  logic                 bcast_wake,
    output logic [ST_W-1:0]      state_o,
    output logic [SUB_W-1:0]     sub_o,
    output logic                 wake_o
);
    cstate_e            state_q, state_d;
    logic [SUB_W-1:0]   sub_q, sub_d;
    logic               mw_q, mw_d;
    logic               wake_q;
    logic               wake_evt;
    logic               code_ok;

    assign code_ok  = (req_state >= ST_MIN_IDLE) && (req_state <= ST_MAX_IDLE);
    assign wake_evt = irq || bcast_wake || (mon_hit && mw_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        sub_d   = sub_q;
        mw_d    = mw_q;
        unique case (state_q)
            ST_C0: begin
                if (req_valid && code_ok && !irq) begin
                    state_d = cstate_e'(req_state);
                    sub_d   = (cstate_e'(req_state) == ST_C6) ? '0 : req_sub;
                    mw_d    = req_mwait;
                end
            end
            ST_C1, ST_C1E, ST_C3, ST_C6: begin
                if (wake_evt) begin
                    state_d = ST_C0;
                    sub_d   = '0;
                    mw_d    = 1'b0;
                end
            end
            default: begin
                state_d = ST_C0;
                sub_d   = '0;
                mw_d    = 1'b0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_C0;
            sub_q   <= '0;
            mw_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            sub_q   <= sub_d;
            mw_q    <= mw_d;
        end
    end

    // Output register: wake pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= (state_q != ST_C0) && wake_evt;
    end

    assign state_o = state_q;
    assign sub_o   = sub_q;
    assign wake_o  = wake_q;

    // R10
    wake_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (state_q == ST_C0) && ($past(state_q) != ST_C0));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_C0 && !wake_evt) |=> $stable(state_q));
    // R8
    c6_nosub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_C6) |-> (sub_q == '0));
    // R9
    wake_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_C0 && irq) |=> (state_q == ST_C0));
endmodule

// File: rtl/cstate_min_tree.sv
module cstate_min_tree
    import cstate_pkg::*;
#(
    parameter int NUM_THR = 2
) (
    input  logic [ST_W*NUM_THR-1:0] states,
    output logic [ST_W-1:0]         min_state
);
    always_comb begin
        min_state = states[ST_W-1:0];
        for (int i = 1; i < NUM_THR; i++) begin
            if (states[i*ST_W +: ST_W] < min_state)
                min_state = states[i*ST_W +: ST_W];
        end
    end
endmodule

// File: rtl/cstate_resolver.sv
module cstate_resolver
    import cstate_pkg::*;
#(
    parameter int NUM_THR = 2,
    parameter int SUB_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_THR-1:0]       req_valid,
    input  logic [3*NUM_THR-1:0]     req_state,
    input  logic [SUB_W*NUM_THR-1:0] req_sub,
    input  logic [NUM_THR-1:0]       req_mwait,
    input  logic [NUM_THR-1:0]       irq,
    input  logic                     mon_hit,
    output logic [3*NUM_THR-1:0]     thr_state,
    output logic [SUB_W*NUM_THR-1:0] thr_sub,
    output logic [2:0]               core_state,
    output logic [NUM_THR-1:0]       wake
);
    logic bcast;

    assign bcast = (core_state == ST_C6) && (|irq);

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        cstate_thread_fsm #(.SUB_W(SUB_W)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_valid  (req_valid[g]),
            .req_state  (req_state[g*ST_W +: ST_W]),
            .req_sub    (req_sub[g*SUB_W +: SUB_W]),
            .req_mwait  (req_mwait[g]),
            .irq        (irq[g]),
            .mon_hit    (mon_hit),
            .bcast_wake (bcast),
            .state_o    (thr_state[g*ST_W +: ST_W]),
            .sub_o      (thr_sub[g*SUB_W +: SUB_W]),
            .wake_o     (wake[g])
        );
    end

    cstate_min_tree #(.NUM_THR(NUM_THR)) u_min (
        .states    (thr_state),
        .min_state (core_state)
    );

    // R7
    c6_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == ST_C6 && |irq) |=> (thr_state == '0 && &wake));
endmodule

// File: tb/tb_cstate_resolver.sv
module tb_cstate_resolver;
    localparam int NT = 2;
    localparam int SW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NT-1:0]     req_valid = '0;
    logic [3*NT-1:0]   req_state = '0;
    logic [SW*NT-1:0]  req_sub = '0;
    logic [NT-1:0]     req_mwait = '0;
    logic [NT-1:0]     irq = '0;
    logic              mon_hit = 1'b0;
    logic [3*NT-1:0]   thr_state;
    logic [SW*NT-1:0]  thr_sub;
    logic [2:0]        core_state;
    logic [NT-1:0]     wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cstate_resolver #(.NUM_THR(NT), .SUB_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
        .req_sub(req_sub), .req_mwait(req_mwait), .irq(irq), .mon_hit(mon_hit),
        .thr_state(thr_state), .thr_sub(thr_sub), .core_state(core_state), .wake(wake)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int st(input int t);
        return int'(thr_state[t*3 +: 3]);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic request(input int t, input int code, input int sub, input bit mw);
        req_valid[t]        = 1'b1;
        req_state[t*3 +: 3] = 3'(code);
        req_sub[t*SW +: SW] = SW'(sub);
        req_mwait[t]        = mw;
    endtask

    task automatic clear_req();
        req_valid = '0; req_state = '0; req_sub = '0; req_mwait = '0;
    endtask

    task automatic wake_all();
        irq = '1; tick(); irq = '0; tick();
    endtask

    task automatic t_reset();
        check("R1 t0 state", st(0), 0);
        check("R1 t1 state", st(1), 0);
        check("R1 core", int'(core_state), 0);
        check("R1 wake", int'(wake), 0);
        check("R1 sub", int'(thr_sub), 0);
    endtask

    task automatic t_resolve();
        request(0, 2, 5, 0); request(1, 3, 2, 0); tick(); clear_req();
        check("R2 t0 C1E", st(0), 2);
        check("R2 t1 C3", st(1), 3);
        check("R8 C3 keeps sub", int'(thr_sub[SW +: SW]), 2);
        check("R3 core min", int'(core_state), 2);
    endtask

    task automatic t_single_wake();
        irq = 2'b10; tick(); irq = '0;
        check("R6 t1 woke", st(1), 0);
        check("R6 t0 stays", st(0), 2);
        check("R10 wake t1 only", int'(wake), 2);
        check("R6 core C0", int'(core_state), 0);
        tick();
        check("R10 pulse one cycle", int'(wake), 0);
        irq = 2'b01; tick(); irq = '0;
        check("R4 t0 woke", st(0), 0);
        check("R10 wake t0", int'(wake), 1);
        tick();
    endtask

    task automatic t_monitor();
        request(0, 1, 0, 1); request(1, 1, 0, 0); tick(); clear_req();
        check("R2 both C1", int'(core_state), 1);
        mon_hit = 1'b1; tick(); mon_hit = 1'b0;
        check("R5 mwait thread woke", st(0), 0);
        check("R5 plain thread stays", st(1), 1);
        check("R5 wake", int'(wake), 1);
        tick();
        wake_all();
    endtask

    task automatic t_c6();
        request(0, 4, 3, 0); request(1, 4, 7, 0); tick(); clear_req();
        check("R3 core C6", int'(core_state), 4);
        check("R8 C6 sub zero", int'(thr_sub), 0);
        irq = 2'b01; tick(); irq = '0;
        check("R7 t0 C0", st(0), 0);
        check("R7 t1 C0", st(1), 0);
        check("R7 wake both", int'(wake), 3);
        tick();
        request(0, 4, 0, 0); request(1, 3, 0, 0); tick(); clear_req();
        check("R3 C6 with C3 core", int'(core_state), 3);
        irq = 2'b01; tick(); irq = '0;
        check("R6 only t0 woke", st(1), 3);
        tick();
        wake_all();
    endtask

    task automatic t_race();
        request(0, 3, 0, 0); irq = 2'b01; tick(); clear_req(); irq = '0;
        check("R9 wake wins", st(0), 0);
        check("R9 no pulse", int'(wake), 0);
    endtask

    task automatic t_ignore();
        request(1, 3, 0, 0); tick(); clear_req();
        request(1, 1, 0, 0); tick(); clear_req();
        check("R11 idle request ignored", st(1), 3);
        wake_all();
        request(0, 5, 0, 0); request(1, 7, 0, 0); tick(); clear_req();
        check("R12 code 5 ignored", st(0), 0);
        check("R12 code 7 ignored", st(1), 0);
        request(0, 0, 0, 0); tick(); clear_req();
        check("R12 code 0 ignored", st(0), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_resolve();
        t_single_wake();
        t_monitor();
        t_c6();
        t_race();
        t_ignore();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule